// File: doc/BRIEF.md
# Memory Access Port Address Unit

This block sits behind a debug port and turns its 32-bit register reads and writes into single memory bus transactions. The debug side presents a byte offset into a 256-byte register window, a write flag and write data. The block answers each access with one response pulse, one WAIT pulse, or, for accesses that touch memory, a response pulse once the memory transaction has finished.

Inside are a control word (access size and address-advance mode), a transfer address register, a data window that reads or writes memory at the transfer address, four banked windows that reach the four words of the 16-byte line holding the transfer address, and read-only configuration, base-pointer and identification words. Only the data and banked windows start memory traffic. After a successful access through the data window, the transfer address can move forward on its own, so software can stream through memory.

Top module: `mem_access_port`

## Requirements
- R1: After reset the transfer address is 0, the control word reads 0x00000042 (size field bits 2:0 = 2 for 32-bit, advance field bits 5:4 = 0, enabled bit 6 = 1, busy bit 7 = 0), and no memory request is raised.
- R2: A write to the control word (offset 0x00) stores the advance field from bits 5:4 and the size field from bits 2:0. A size value above 2 is stored as 2. All other control bits read back as their fixed values.
- R3: A read or write of the transfer address register (offset 0x04) is answered on the next cycle and never raises a memory request. A read returns the last value written.
- R4: A write to the data window (offset 0x0C) raises one memory write carrying the transfer address, the written data and the current size code (0 byte, 1 halfword, 2 word). The debug response arrives in the cycle after the memory response.
- R5: A read of the data window raises one memory read at the transfer address. The debug response carries the memory read data and arrives in the cycle after the memory response.
- R6: Banked window n at offset 0x10 + 4n accesses address {transfer address[31:4], n, 2'b00}.
- R7: After a successful data-window access, the advance field sets the change to the transfer address. A value of 0 leaves it unchanged, 1 adds the access size in bytes (1, 2 or 4), 2 (packed) adds 4, and 3 leaves it unchanged.
- R8: Banked window accesses never change the transfer address.
- R9: A memory error response gives a debug response with the error flag set, and the transfer address is not advanced.
- R10: A debug access that arrives while a memory transaction is outstanding gets a one-cycle WAIT pulse instead of a response and changes no state.
- R11: Offset 0xFC reads {revision[3:0], designer[10:0], 4'h8, 5'b0, variant[3:0], type[3:0]}. Offset 0xF4 reads 0. Offset 0xF8 reads the base parameter. Any other unmapped offset reads 0, and writes to read-only or unmapped offsets have no effect.
- R12: While a memory request is raised, its address, write flag, data and size stay constant until the memory response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dbg_req | input | 1 | Debug access strobe, one cycle |
| dbg_wr | input | 1 | 1 = write, 0 = read |
| dbg_addr | input | 8 | Register byte offset (bits 1:0 ignored) |
| dbg_wdata | input | 32 | Register write data |
| dbg_ack | output | 1 | Access response pulse |
| dbg_wait | output | 1 | WAIT pulse: access refused while busy |
| dbg_err | output | 1 | Memory error, valid with dbg_ack |
| dbg_rdata | output | 32 | Read data, valid with dbg_ack |
| mem_req | output | 1 | Memory request, held until mem_rsp |
| mem_wr | output | 1 | Memory write flag |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_size | output | 2 | Access size code: 0 byte, 1 halfword, 2 word |
| mem_rsp | input | 1 | Memory response pulse |
| mem_rdata | input | 32 | Memory read data |
| mem_err | input | 1 | Memory error, valid with mem_rsp |

## Verification
The bench goes after the address arithmetic. It checks single advance at every size, so a design that always adds 4 breaks on byte and halfword steps. It checks that packed mode adds 4 even for byte accesses and that mode 3 leaves the address in place, which catches a design that decodes only one bit of the field. It places the transfer address mid-line with nonzero low bits, so a design that keeps those bits in banked addresses, or that lets banked accesses advance the address, shows a wrong address on the bus. It also sends an error response in single mode and an access during a pending read: a design that advances on error, or that lets the refused write land in the address register, reads back a wrong transfer address.

// File: rtl/mem_access_port.sv
module mem_access_port #(
  parameter logic [3:0]  ID_REV      = 4'h1,
  parameter logic [10:0] ID_DESIGNER = 11'h23B,
  parameter logic [3:0]  ID_VARIANT  = 4'h0,
  parameter logic [3:0]  ID_TYPE     = 4'h1,
  parameter logic [31:0] BASE_PTR    = 32'hE00F_F003
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        dbg_req,
  input  logic        dbg_wr,
  input  logic [7:0]  dbg_addr,
  input  logic [31:0] dbg_wdata,
  output logic        dbg_ack,
  output logic        dbg_wait,
  output logic        dbg_err,
  output logic [31:0] dbg_rdata,
  output logic        mem_req,
  output logic        mem_wr,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic [1:0]  mem_size,
  input  logic        mem_rsp,
  input  logic [31:0] mem_rdata,
  input  logic        mem_err
);
  localparam logic [5:0] W_CTRL = 6'h00, W_TADR = 6'h01, W_DATA = 6'h03;
  localparam logic [5:0] W_CFG  = 6'h3D, W_BASE = 6'h3E, W_IDEN = 6'h3F;
  localparam logic [3:0] CLASS_MEM = 4'h8;

  logic [31:0] tadr;
  logic [1:0]  sz, adv;
  logic        via_data;

  wire [5:0] word    = dbg_addr[7:2];
  wire       is_bank = (word[5:2] == 4'h1);
  wire       is_mem  = is_bank || (word == W_DATA);
  wire       take    = dbg_req && !mem_req;
  wire [1:0] sz_new  = (dbg_wdata[2:0] > 3'd2) ? 2'd2 : dbg_wdata[1:0];

  wire [31:0] step = (adv == 2'd1) ? (32'd1 << sz) :
                     (adv == 2'd2) ? 32'd4 : 32'd0;

  logic [31:0] rd_mux;
  always_comb begin
    case (word)
      W_CTRL:  rd_mux = {24'd0, mem_req, 1'b1, adv, 2'b00, sz};
      W_TADR:  rd_mux = tadr;
      W_CFG:   rd_mux = 32'd0;
      W_BASE:  rd_mux = BASE_PTR;
      W_IDEN:  rd_mux = {ID_REV, ID_DESIGNER, CLASS_MEM, 5'd0, ID_VARIANT, ID_TYPE};
      default: rd_mux = 32'd0;
    endcase
  end

  assign mem_size = sz;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tadr      <= '0;
      sz        <= 2'd2;
      adv       <= 2'd0;
      via_data  <= 1'b0;
      mem_req   <= 1'b0;
      mem_wr    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      dbg_ack   <= 1'b0;
      dbg_wait  <= 1'b0;
      dbg_err   <= 1'b0;
      dbg_rdata <= '0;
    end else begin
      dbg_ack  <= 1'b0;
      dbg_wait <= dbg_req && mem_req;
      dbg_err  <= 1'b0;
      if (mem_req && mem_rsp) begin
        mem_req   <= 1'b0;
        dbg_ack   <= 1'b1;
        dbg_err   <= mem_err;
        dbg_rdata <= mem_wr ? 32'd0 : mem_rdata;
        if (via_data && !mem_err) tadr <= tadr + step;
      end else if (take) begin
        if (is_mem) begin
          mem_req   <= 1'b1;
          mem_wr    <= dbg_wr;
          mem_wdata <= dbg_wr ? dbg_wdata : 32'd0;
          mem_addr  <= is_bank ? {tadr[31:4], word[1:0], 2'b00} : tadr;
          via_data  <= !is_bank;
        end else begin
          dbg_ack   <= 1'b1;
          dbg_rdata <= dbg_wr ? 32'd0 : rd_mux;
          if (dbg_wr && word == W_CTRL) begin
            sz  <= sz_new;
            adv <= dbg_wdata[5:4];
          end
          if (dbg_wr && word == W_TADR) tadr <= dbg_wdata;
        end
      end
    end
  end
endmodule

// File: rtl/mem_access_port_chk.sv
module mem_access_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        dbg_req,
  input logic [7:0]  dbg_addr,
  input logic        dbg_ack,
  input logic        dbg_wait,
  input logic        dbg_err,
  input logic        mem_req,
  input logic        mem_wr,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic [1:0]  mem_size,
  input logic        mem_rsp
);
  p_no_tadr_mem_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_req && !mem_req && dbg_addr[7:2] == 6'h01) |=> !mem_req);

  p_rsp_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_rsp) |=> (dbg_ack && !mem_req));

  p_err_with_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_err |-> dbg_ack);

  p_wait_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_req && mem_req) |=> (dbg_wait && !dbg_ack));

  p_wait_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_wait |-> $past(mem_req));

  p_req_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rsp) |=> (mem_req && $stable(mem_addr) && $stable(mem_wr)
                               && $stable(mem_wdata) && $stable(mem_size)));

  p_size_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_size != 2'd3));
endmodule

bind mem_access_port mem_access_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dbg_req(dbg_req), .dbg_addr(dbg_addr),
  .dbg_ack(dbg_ack), .dbg_wait(dbg_wait), .dbg_err(dbg_err),
  .mem_req(mem_req), .mem_wr(mem_wr), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_size(mem_size), .mem_rsp(mem_rsp)
);

// File: tb/tb_mem_access_port.sv
`timescale 1ns/1ps
module tb_mem_access_port;
  logic clk = 1'b0, rst_n = 1'b0;
  logic dbg_req = 0, dbg_wr = 0;
  logic [7:0] dbg_addr = 0;
  logic [31:0] dbg_wdata = 0;
  logic dbg_ack, dbg_wait, dbg_err;
  logic [31:0] dbg_rdata;
  logic mem_req, mem_wr;
  logic [31:0] mem_addr, mem_wdata;
  logic [1:0] mem_size;
  logic mem_rsp = 0, mem_err = 0;
  logic [31:0] mem_rdata = 0;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mem_access_port dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(logic wr, logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    dbg_req = 1; dbg_wr = wr; dbg_addr = a; dbg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    dbg_req = 0;
  endtask

  task automatic reg_wr(string req, logic [7:0] a, logic [31:0] d);
    issue(1, a, d);
    chk({req, " ack"}, dbg_ack, 1);
    chk({req, " no mem"}, mem_req, 0);
  endtask

  task automatic reg_rd(string req, logic [7:0] a, logic [31:0] exp);
    issue(0, a, 0);
    chk({req, " ack"}, dbg_ack, 1);
    chk({req, " no mem"}, mem_req, 0);
    chk({req, " rdata"}, dbg_rdata, exp);
  endtask

  // at a negedge with mem_req visible: check request, respond, check debug answer
  task automatic serve(string req, logic wr, logic [31:0] addr, logic [31:0] wd,
                       logic [1:0] sz, logic [31:0] rd, logic err);
    chk({req, " mem_req"}, mem_req, 1);
    chk({req, " mem_wr"}, mem_wr, wr);
    chk({req, " mem_addr"}, mem_addr, addr);
    if (wr) chk({req, " mem_wdata"}, mem_wdata, wd);
    chk({req, " mem_size"}, mem_size, sz);
    chk({req, " no early ack"}, dbg_ack, 0);
    mem_rsp = 1; mem_rdata = rd; mem_err = err;
    @(posedge clk);
    @(negedge clk);
    mem_rsp = 0; mem_err = 0;
    chk({req, " ack"}, dbg_ack, 1);
    chk({req, " err"}, dbg_err, err);
    if (!wr) chk({req, " rdata"}, dbg_rdata, rd);
    chk({req, " req dropped"}, mem_req, 0);
  endtask

  task automatic t_reset;
    reg_rd("R1 ctrl", 8'h00, 32'h42);
    reg_rd("R1 tadr", 8'h04, 32'h0);
  endtask

  task automatic t_ctrl;
    reg_wr("R2", 8'h00, 32'hFFFF_FF15);
    reg_rd("R2 clamp/adv", 8'h00, 32'h0000_0052);
    reg_wr("R2", 8'h00, 32'h0000_0001);
    reg_rd("R2 size1", 8'h00, 32'h0000_0041);
    reg_wr("R2", 8'h00, 32'h0000_0002);
  endtask

  task automatic t_tadr;
    reg_wr("R3", 8'h04, 32'h1234_5678);
    reg_rd("R3 readback", 8'h04, 32'h1234_5678);
  endtask

  task automatic t_drw;
    reg_wr("R4", 8'h04, 32'h0000_2000);
    issue(1, 8'h0C, 32'hCAFE_F00D);
    serve("R4 write", 1, 32'h2000, 32'hCAFE_F00D, 2, 0, 0);
    issue(0, 8'h0C, 0);
    serve("R5 read", 0, 32'h2000, 0, 2, 32'hA5A5_0001, 0);
    reg_rd("R7 adv off", 8'h04, 32'h2000);
  endtask

  task automatic t_banked;
    reg_wr("R6", 8'h00, 32'h12);
    reg_wr("R6", 8'h04, 32'h0000_4A37);
    for (int n = 0; n < 4; n++) begin
      issue(n[0], 8'h10 + 8'(4 * n), 32'h100 + n);
      serve("R6 bank", n[0], 32'h4A30 + 32'(4 * n), 32'h100 + n, 2, 32'h55 + n, 0);
    end
    reg_rd("R8 no advance", 8'h04, 32'h0000_4A37);
  endtask

  task automatic t_incr;
    reg_wr("R7", 8'h04, 32'h100);
    reg_wr("R7", 8'h00, 32'h10);
    issue(0, 8'h0C, 0); serve("R7 single b", 0, 32'h100, 0, 0, 32'h1, 0);
    reg_rd("R7 +1", 8'h04, 32'h101);
    reg_wr("R7", 8'h00, 32'h11);
    issue(1, 8'h0C, 32'h7); serve("R7 single h", 1, 32'h101, 32'h7, 1, 0, 0);
    reg_rd("R7 +2", 8'h04, 32'h103);
    reg_wr("R7", 8'h00, 32'h12);
    issue(0, 8'h0C, 0); serve("R7 single w", 0, 32'h103, 0, 2, 32'h9, 0);
    reg_rd("R7 +4", 8'h04, 32'h107);
    reg_wr("R7", 8'h00, 32'h20);
    issue(0, 8'h0C, 0); serve("R7 packed", 0, 32'h107, 0, 0, 32'h3, 0);
    reg_rd("R7 packed +4", 8'h04, 32'h10B);
    reg_wr("R7", 8'h00, 32'h32);
    issue(0, 8'h0C, 0); serve("R7 mode3", 0, 32'h10B, 0, 2, 32'h4, 0);
    reg_rd("R7 mode3 hold", 8'h04, 32'h10B);
  endtask

  task automatic t_error;
    reg_wr("R9", 8'h00, 32'h12);
    reg_wr("R9", 8'h04, 32'h800);
    issue(0, 8'h0C, 0);
    serve("R9 err", 0, 32'h800, 0, 2, 32'h0, 1);
    reg_rd("R9 no advance", 8'h04, 32'h800);
  endtask

  task automatic t_wait;
    reg_wr("R10", 8'h00, 32'h02);
    reg_wr("R10", 8'h04, 32'h300);
    issue(0, 8'h0C, 0);
    issue(1, 8'h04, 32'hDEAD_BEEF);
    chk("R10 wait", dbg_wait, 1);
    chk("R10 no ack", dbg_ack, 0);
    @(negedge clk);
    chk("R10 wait one cycle", dbg_wait, 0);
    chk("R12 addr held", mem_addr, 32'h300);
    serve("R10 pending", 0, 32'h300, 0, 2, 32'h77, 0);
    reg_rd("R10 tadr kept", 8'h04, 32'h300);
  endtask

  task automatic t_ro;
    reg_rd("R11 iden", 8'hFC, {4'h1, 11'h23B, 4'h8, 5'd0, 4'h0, 4'h1});
    reg_rd("R11 cfg", 8'hF4, 32'h0);
    reg_rd("R11 base", 8'hF8, 32'hE00F_F003);
    reg_wr("R11", 8'hFC, 32'hFFFF_FFFF);
    reg_wr("R11", 8'h40, 32'hFFFF_FFFF);
    reg_rd("R11 iden kept", 8'hFC, {4'h1, 11'h23B, 4'h8, 5'd0, 4'h0, 4'h1});
    reg_rd("R11 unmapped", 8'h40, 32'h0);
    reg_rd("R11 ctrl kept", 8'h00, 32'h42);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 mem_req reset", mem_req, 0);
    rst_n = 1;
    t_reset(); t_ctrl(); t_tadr(); t_drw(); t_banked();
    t_incr(); t_error(); t_wait(); t_ro();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule